// File: doc/BRIEF.md
# Two-Channel Wiper Code Register with Serial Slave Port

This block is the digital front end of a dual digitally controlled resistor. It listens on a two-wire serial bus (I2C-compatible, 7-bit addressing) as a slave. It oversamples the clock and data lines with the system clock and keeps one 8-bit wiper code and one shutdown flag for each of two channels. The codes and flags drive an analog ladder decoder directly.

A write transaction carries three kinds of byte: the address byte, then an instruction byte that picks the channel and sets its shutdown flag, then any number of data bytes. Every data byte lands in the channel that the instruction picked. A read transaction has no pointer. It returns the code of the channel picked by the most recent instruction byte, and it keeps returning that code for as long as the master acknowledges. The block drives the data line only through an open-drain enable, and it never stretches the clock.

There is no streaming data path at the block's edge. The bus pins, strap pins, codes and flags are all plain level signals, so there is no valid/ready interface and no back-pressure.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset both wiper codes are 0x80, both shutdown flags are 0, the channel selection is channel A, and `sda_oe` is 0.
- R2: The slave address is binary 01011 followed by `addr_pins[1]` and `addr_pins[0]`. The address byte carries it in bits 7:1 and the read flag in bit 0 (1 means read). Only a matching address is acknowledged, by pulling SDA low for the ninth clock pulse. After a mismatch, no later byte is acknowledged and no state changes until the next START.
- R3: In a write, the first byte after the address is the instruction. Bit 7 selects the channel (0 = A, 1 = B) and bit 6 is the shutdown value for that channel. Bits 5:0 have no effect. The instruction byte is acknowledged.
- R4: Each data byte after the instruction is stored in the selected channel's wiper code and acknowledged. The other channel keeps its code.
- R5: Any number of data bytes in one write transaction all update the same selected channel.
- R6: In a read, the first data bit is driven right after the address acknowledge. The byte is the code of the channel selected by the most recent instruction byte, even if that write carried no data byte.
- R7: A read keeps sending the selected code while the master acknowledges each byte. After a not-acknowledge the slave releases SDA until the next START or STOP.
- R8: The shutdown flag of the addressed channel takes bit 6 of each instruction byte. Changing a shutdown flag never alters a wiper code. Data written while a channel is shut down is stored.
- R9: A START or STOP in the middle of a byte abandons the transaction. The partial byte has no effect, and a START begins a new address phase.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_pins | input | 2 | Strap pins giving the two low address bits |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| wiper_a | output | 8 | Wiper code of channel A |
| wiper_b | output | 8 | Wiper code of channel B |
| sleep_a | output | 1 | Shutdown flag of channel A |
| sleep_b | output | 1 | Shutdown flag of channel B |

## Verification
The bench builds the block with its default parameters: the 01011 address prefix, a two-stage synchronizer and midscale reset. It straps the low address bits to 10, and it also tries all four strap patterns once each. The SCL half period of eight system clocks makes full sweeps affordable. All 128 addresses are offered, and every one of the 256 codes is streamed through a single write into each channel and checked at the outputs byte by byte. Directed transactions then cover pointerless reads, shutdown while writing, and aborts in the middle of a byte.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int NCH    = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_INSTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_SKIP
  } bus_state_t;

  typedef struct packed {
    logic chan;
    logic sleep;
  } instr_t;
endpackage

// File: rtl/wiper_bus_sync.sv
module wiper_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  // Both lines idle high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[LAST];
      sda_prev <= sda_pipe[LAST];
    end
  end

  assign scl_s     = scl_pipe[LAST];
  assign sda_s     = sda_pipe[LAST];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  // SDA edges while SCL stays high mark frame boundaries.
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/wiper_link_fsm.sv
module wiper_link_fsm
  import wiper_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b01011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        addr_pins,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              instr_valid,
  output instr_t            instr,
  output logic              data_valid,
  output logic [BYTE_W-1:0] data_byte
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  bus_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              rd_mode;
  logic [6:0]        dev_addr;

  assign dev_addr = {ADDR_FIXED, addr_pins};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      txreg       <= '0;
      rd_mode     <= 1'b0;
      instr_valid <= 1'b0;
      data_valid  <= 1'b0;
    end else begin
      instr_valid <= 1'b0;
      data_valid  <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_ADDR, ST_INSTR, ST_DATA: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == dev_addr) begin
                  rd_mode <= shreg[0];
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_INSTR) begin
                instr_valid <= 1'b1;
                state       <= ST_INSTR_ACK;
              end else begin
                data_valid <= 1'b1;
                state      <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                txreg <= rd_data;
                state <= ST_RD_BYTE;
              end else begin
                state <= ST_INSTR;
              end
            end
          end
          ST_INSTR_ACK, ST_DATA_ACK: begin
            if (scl_fall) state <= ST_DATA;
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                cnt   <= '0;
                state <= ST_RD_ACK;
              end else begin
                cnt   <= cnt + 1'b1;
                txreg <= {txreg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_SKIP;
            end else if (scl_fall) begin
              txreg <= rd_data;
              state <= ST_RD_BYTE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
      ST_RD_BYTE:                             sda_oe = ~txreg[BYTE_W-1];
      default:                                sda_oe = 1'b0;
    endcase
  end

  assign instr.chan  = shreg[BYTE_W-1];
  assign instr.sleep = shreg[BYTE_W-2];
  assign data_byte   = shreg;
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_CODE = 8'h80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  input  instr_t                     instr,
  input  logic                       data_valid,
  input  logic [BYTE_W-1:0]          data_byte,
  output logic [NCH-1:0][BYTE_W-1:0] code_q,
  output logic [NCH-1:0]             sleep_q,
  output logic [BYTE_W-1:0]          rd_data
);
  localparam int SEL_W = $clog2(NCH);

  logic [SEL_W-1:0] sel_q;
  logic [NCH-1:0]   wr_en;
  logic [NCH-1:0]   ins_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sel_q <= '0;
    else if (instr_valid) sel_q <= SEL_W'(instr.chan);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign wr_en[g]  = data_valid  && (sel_q == SEL_W'(g));
    assign ins_en[g] = instr_valid && (SEL_W'(instr.chan) == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q[g] <= RESET_CODE;
      else if (wr_en[g]) code_q[g] <= data_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sleep_q[g] <= 1'b0;
      else if (ins_en[g]) sleep_q[g] <= instr.sleep;
    end
  end

  assign rd_data = code_q[sel_q];
endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave
  import wiper_pkg::*;
#(
  parameter logic [4:0]        ADDR_FIXED  = 5'b01011,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] RESET_CODE  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_pins,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] wiper_a,
  output logic [BYTE_W-1:0] wiper_b,
  output logic              sleep_a,
  output logic              sleep_b
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic instr_valid, data_valid;
  instr_t instr;
  logic [BYTE_W-1:0] data_byte;
  logic [BYTE_W-1:0] rd_data;
  logic [NCH-1:0][BYTE_W-1:0] code_q;
  logic [NCH-1:0] sleep_q;

  wiper_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  wiper_link_fsm #(.ADDR_FIXED(ADDR_FIXED)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .addr_pins   (addr_pins),
    .rd_data     (rd_data),
    .sda_oe      (sda_oe),
    .instr_valid (instr_valid),
    .instr       (instr),
    .data_valid  (data_valid),
    .data_byte   (data_byte)
  );

  wiper_bank #(.RESET_CODE(RESET_CODE)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .data_valid  (data_valid),
    .data_byte   (data_byte),
    .code_q      (code_q),
    .sleep_q     (sleep_q),
    .rd_data     (rd_data)
  );

  assign wiper_a = code_q[0];
  assign wiper_b = code_q[1];
  assign sleep_a = sleep_q[0];
  assign sleep_b = sleep_q[1];
endmodule

// File: rtl/wiper_slave_chk.sv
module wiper_slave_chk #(
  parameter logic [7:0] RESET_CODE = 8'h80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       instr_valid,
  input logic       data_valid,
  input logic [7:0] wiper_a,
  input logic [7:0] wiper_b,
  input logic       sleep_a,
  input logic       sleep_b
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (wiper_a == RESET_CODE && wiper_b == RESET_CODE &&
                       !sleep_a && !sleep_b && !sda_oe));

  assert_code_from_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wiper_a) || !$stable(wiper_b)) |-> $past(data_valid));

  assert_single_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_valid) |-> ($stable(wiper_a) || $stable(wiper_b)));

  assert_sleep_from_instr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sleep_a) || !$stable(sleep_b)) |-> $past(instr_valid));

  assert_sleep_keeps_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sleep_a) || !$stable(sleep_b)) |-> ($stable(wiper_a) && $stable(wiper_b)));

  assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

bind i2c_wiper_slave wiper_slave_chk #(.RESET_CODE(RESET_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_s),
  .sda_oe      (sda_oe),
  .instr_valid (instr_valid),
  .data_valid  (data_valid),
  .wiper_a     (wiper_a),
  .wiper_b     (wiper_b),
  .sleep_a     (sleep_a),
  .sleep_b     (sleep_b)
);

// File: tb/tb_i2c_wiper_slave.sv
module tb_i2c_wiper_slave;
  localparam int H = 8;
  localparam logic [1:0] PINS = 2'b10;
  localparam logic [6:0] MYADDR = {5'b01011, PINS};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] pins = PINS;
  logic sda_oe, sleep_a, sleep_b;
  logic [7:0] wiper_a, wiper_b;
  wire sda_bus = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  int r10_glitch = 0;
  logic ack;
  logic [7:0] rd;

  always #2 clk = ~clk;

  i2c_wiper_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_pins(pins), .sda_oe(sda_oe), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .sleep_a(sleep_a), .sleep_b(sleep_b)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0;   tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(H);
      scl = 1'b1;     tick(H);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    send_bits(b, 8);
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H/2);
    a = ~sda_bus; tick(H/2);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic early;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      scl = 1'b1; tick(1);
      early = sda_bus; tick(H/2 - 1);
      d[7-i] = sda_bus; tick(H/2 - 1);
      if (early != sda_bus) r10_glitch++;
      tick(1);
      scl = 1'b0;
    end
    sda_m = ~mack; tick(H);
    scl = 1'b1;    tick(H);
    scl = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] d);
    logic a;
    bus_start();
    send_byte({MYADDR, 1'b1}, a);
    chk("R6 read address ack", a, 1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk("R1 wiper_a", wiper_a, 8'h80);
    chk("R1 wiper_b", wiper_b, 8'h80);
    chk("R1 sleep flags", {sleep_a, sleep_b}, 0);
    chk("R1 sda_oe", sda_oe, 0);
    do_read(rd);
    chk("R1 reset selection is channel A", rd, 8'h80);

    // R2 address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      bus_stop();
      chk($sformatf("R2 ack for address %0h", a), ack, (7'(a) == MYADDR) ? 1 : 0);
    end
    // R2 strap patterns
    for (int p = 0; p < 4; p++) begin
      pins = 2'(p);
      bus_start();
      send_byte({5'b01011, 2'(p), 1'b0}, ack);
      bus_stop();
      chk("R2 strapped address acked", ack, 1);
      bus_start();
      send_byte({5'b01011, ~2'(p), 1'b0}, ack);
      bus_stop();
      chk("R2 other strap not acked", ack, 0);
    end
    pins = PINS;
    // R2 mismatch then bytes are ignored
    bus_start();
    send_byte({MYADDR ^ 7'h01, 1'b0}, ack);
    send_byte(8'h40, ack);
    chk("R2 no ack after mismatch", ack, 0);
    send_byte(8'h11, ack);
    bus_stop();
    chk("R2 wiper_a untouched after mismatch", wiper_a, 8'h80);
    chk("R2 sleep_a untouched after mismatch", sleep_a, 0);

    // R3/R4 instruction with junk low bits, write channel B
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'hAA, ack);
    chk("R3 instruction acked", ack, 1);
    chk("R3 junk bits leave sleep_b clear", sleep_b, 0);
    send_byte(8'h37, ack);
    chk("R4 data acked", ack, 1);
    bus_stop();
    chk("R4 wiper_b loaded", wiper_b, 8'h37);
    chk("R4 wiper_a kept", wiper_a, 8'h80);

    // R5 stream all codes into channel A
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h00, ack);
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), ack);
      chk("R5 stream A code", wiper_a, v);
      chk("R5 stream A keeps B", wiper_b, 8'h37);
    end
    bus_stop();
    // R5 stream complemented codes into channel B
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h80, ack);
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(255 - v), ack);
      chk("R5 stream B code", wiper_b, 255 - v);
      chk("R5 stream B keeps A", wiper_a, 8'hFF);
    end
    bus_stop();

    // R6 read returns last selected channel
    do_read(rd);
    chk("R6 read channel B", rd, 8'h00);
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h00, ack);
    bus_stop();
    do_read(rd);
    chk("R6 instruction-only write reselects A", rd, 8'hFF);

    // R7 repeated read bytes, then release after NACK
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h00, ack);
    send_byte(8'h5A, ack);
    bus_stop();
    bus_start();
    send_byte({MYADDR, 1'b1}, ack);
    for (int k = 0; k < 3; k++) begin
      recv_byte(1'b1, rd);
      chk("R7 repeated read byte", rd, 8'h5A);
    end
    recv_byte(1'b0, rd);
    chk("R7 last read byte", rd, 8'h5A);
    recv_byte(1'b0, rd);
    chk("R7 bus released after nack", rd, 8'hFF);
    bus_stop();

    // R8 shutdown handling
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h40, ack);
    chk("R8 sleep_a set by instruction", sleep_a, 1);
    chk("R8 code kept while entering shutdown", wiper_a, 8'h5A);
    send_byte(8'h21, ack);
    bus_stop();
    chk("R8 write while shut down stored", wiper_a, 8'h21);
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'hC0, ack);
    bus_stop();
    chk("R8 sleep_b set", sleep_b, 1);
    chk("R8 sleep_a held", sleep_a, 1);
    chk("R8 wiper_b kept", wiper_b, 8'h00);
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h00, ack);
    bus_stop();
    chk("R8 sleep_a cleared", sleep_a, 0);
    chk("R8 sleep_b still set", sleep_b, 1);
    do_read(rd);
    chk("R8 stored code after shutdown", rd, 8'h21);

    // R9 aborts in the middle of a byte
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h80, ack);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    chk("R9 address after mid-byte start acked", ack, 1);
    send_byte(8'h00, ack);
    send_byte(8'h66, ack);
    bus_stop();
    chk("R9 new transaction wrote A", wiper_a, 8'h66);
    chk("R9 aborted byte left B", wiper_b, 8'h00);
    bus_start();
    send_byte({MYADDR, 1'b0}, ack);
    send_byte(8'h00, ack);
    send_bits(8'h99, 5);
    bus_stop();
    chk("R9 partial byte before stop ignored", wiper_a, 8'h66);
    do_read(rd);
    chk("R9 read after stop abort", rd, 8'h66);

    // R10 slave-driven SDA steady through every SCL high phase
    chk("R10 sda steady while scl high", r10_glitch, 0);

    finish_run();
  end
endmodule